// File: doc/BRIEF.md
# Audio Clock Ratio and Speed Detector

This block runs on the audio master clock. It looks at the frame (left/right) clock and at a slow reference tick, and works out how the two audio clocks relate to each other. It needs no configuration pins. It counts master clock cycles between rising edges of the frame clock to find the master-to-frame ratio. It also counts master clock cycles across a fixed reference window, which gives a measure of the absolute master clock rate. From that rate it tells single speed (32 to 48 kHz frames), double speed (64 to 96 kHz) and quad speed (128 to 192 kHz) apart.

Several ratios are legal in more than one speed mode, for example 128x, 192x, 256x, 384x and 512x. For these, the ratio alone cannot give the mode. The block divides the rate count by the matched ratio, which gives a figure proportional to the frame rate, and compares it with two thresholds. The block accepts a result only when two consecutive frame periods agree and the ratio is legal in the detected mode. It then reports a divider setting. A clock generator downstream uses that setting to build a bit clock of 64 times the frame rate.

All clocks are assumed to be synchronous. The frame clock and the reference tick are sampled directly by the master clock, with no synchronizer.

Top module: `clk_ratio_detector`

## Requirements
- R1: While reset is high, and on the first cycle after it, `valid_o` is 0, `ratio_code_o` is 0, `speed_o` is 0 and `bclk_div_half_o` is 0.
- R2: A frame period is the number of master clock cycles from one sampled rising edge of the frame clock to the next. A period is matched to a nominal ratio when it lies within ±TOL cycles (default 2) of that ratio. The ratio codes are: 64x=0, 96x=1, 128x=2, 192x=3, 256x=4, 384x=5, 512x=6, 768x=7, 1024x=8, 1152x=9. A period that matches no ratio gives `valid_o` = 0.
- R3: A result is accepted only when the current period and the previous period differ by no more than TOL. The first acceptance after a period change therefore comes at the second rising edge that closes a period of the new length.
- R4: The rate count is the number of master clock cycles spanned by WIN_TICKS reference ticks. Counting starts at the first tick after reset, and the count is refreshed at every WIN_TICKS-th tick after that.
- R5: The speed mode is found from the rate count C and the matched nominal ratio N. It is quad (code 2) if C >= N*QUAD_MIN, else double (code 1) if C >= N*DBL_MIN, else single (code 0).
- R6: Quad speed allows 64x, 96x, 128x and 192x. Double speed allows 128x to 512x. Single speed allows 256x to 1152x. A ratio that is not allowed in the detected mode gives `valid_o` = 0.
- R7: When a result is rejected, `valid_o` goes to 0 and the ratio code, speed and divider keep their last accepted values.
- R8: When `valid_o` is 1, `bclk_div_half_o` equals N/32. This is the bit clock period in half master clock periods, so that the bit clock runs at 64 times the frame rate.
- R9: The outputs change only on the master clock edge that first samples the frame clock high after it was low.
- R10: `valid_o` stays 0 until the first rate window has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master clock; all logic runs on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| frame_clk_i | input | 1 | Left/right frame clock, synchronous to the master clock |
| ref_tick_i | input | 1 | One-cycle strobe from a free-running reference, marks window boundaries |
| valid_o | output | 1 | Detection accepted |
| ratio_code_o | output | 4 | Detected ratio code (R2 encoding) |
| speed_o | output | 2 | Speed mode: 0 single, 1 double, 2 quad |
| bclk_div_half_o | output | 6 | Bit clock divider in half master clock periods |

## Verification
Every output register is loaded on the master clock edge that samples the frame clock rising. For the timing checks, the bench waits for its own frame clock edge and then for the next master clock edge, and samples 2 ns after it. At that point the rejection at the first new period (R3), and the acceptance at the second, are both due. The rate result lags by up to two reference windows. For that reason the table-driven checks wait for two old windows, two new windows and six frame periods before sampling. A monitor compares the outputs at every cycle and confirms that they move only when the sampled frame clock goes from low to high.

// File: rtl/clkdet_pkg.sv
package clkdet_pkg;

    localparam int unsigned NUM_RATIOS     = 10;
    localparam int unsigned CODE_W         = 4;
    localparam int unsigned DIV_W          = 6;
    localparam int unsigned MAX_RATIO      = 1152;
    localparam int unsigned BCLK_PER_FRAME = 64;

    typedef logic [CODE_W-1:0] ratio_code_t;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'd0,
        SPD_DOUBLE = 2'd1,
        SPD_QUAD   = 2'd2
    } speed_e;

    typedef struct packed {
        logic             valid;
        ratio_code_t      code;
        speed_e           speed;
        logic [DIV_W-1:0] div_half;
    } det_result_t;

    // Nominal master cycles per frame for each ratio code
    function automatic int unsigned ratio_of(input ratio_code_t c);
        case (c)
            4'd0:    return 64;
            4'd1:    return 96;
            4'd2:    return 128;
            4'd3:    return 192;
            4'd4:    return 256;
            4'd5:    return 384;
            4'd6:    return 512;
            4'd7:    return 768;
            4'd8:    return 1024;
            4'd9:    return 1152;
            default: return 0;
        endcase
    endfunction

    // Ratio window allowed in each speed mode
    function automatic logic legal_in(input speed_e s, input ratio_code_t c);
        case (s)
            SPD_QUAD:   return (c <= 4'd3);
            SPD_DOUBLE: return (c >= 4'd2) && (c <= 4'd6);
            SPD_SINGLE: return (c >= 4'd4) && (c <= 4'd9);
            default:    return 1'b0;
        endcase
    endfunction

    // Bit clock period in half master periods: ratio / (64 / 2)
    function automatic logic [DIV_W-1:0] half_div_of(input ratio_code_t c);
        return DIV_W'((ratio_of(c) * 2) / BCLK_PER_FRAME);
    endfunction

    function automatic int unsigned abs_diff(input int unsigned a, input int unsigned b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/frame_period_meter.sv
module frame_period_meter
    import clkdet_pkg::*;
#(
    parameter int unsigned PER_W = 11
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             frame_clk_i,
    output logic             rise_o,
    output logic             period_evt_o,
    output logic [PER_W-1:0] period_o
);

    localparam logic [PER_W-1:0] CNT_MAX = '1;

    logic             frame_q;
    logic             armed_q;
    logic [PER_W-1:0] cnt_q;

    assign rise_o       = frame_clk_i & ~frame_q;
    assign period_evt_o = rise_o & armed_q;
    assign period_o     = cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            frame_q <= 1'b1;
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            frame_q <= frame_clk_i;
            if (rise_o) begin
                armed_q <= 1'b1;
                cnt_q   <= PER_W'(1);
            end else if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + PER_W'(1);
            end
        end
    end

    AST_PERIOD_RESTART: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |=> (cnt_q == PER_W'(1))); // R2

    AST_PERIOD_NO_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        (!rise_o && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R2

endmodule

// File: rtl/mclk_rate_meter.sv
module mclk_rate_meter
    import clkdet_pkg::*;
#(
    parameter int unsigned WIN_TICKS = 4,
    parameter int unsigned RATE_W    = 20
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ref_tick_i,
    output logic [RATE_W-1:0] rate_o,
    output logic              rate_ok_o
);

    localparam int unsigned TICK_W = $clog2(WIN_TICKS + 1);
    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(WIN_TICKS - 1);
    localparam logic [RATE_W-1:0] RUN_MAX = '1;

    logic              started_q;
    logic [TICK_W-1:0] tick_n_q;
    logic [RATE_W-1:0] run_q;
    logic [RATE_W-1:0] run_inc;

    assign run_inc = (run_q == RUN_MAX) ? run_q : run_q + RATE_W'(1);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            started_q <= 1'b0;
            tick_n_q  <= '0;
            run_q     <= '0;
            rate_o    <= '0;
            rate_ok_o <= 1'b0;
        end else if (ref_tick_i) begin
            if (!started_q) begin
                started_q <= 1'b1;
                tick_n_q  <= '0;
                run_q     <= RATE_W'(1);
            end else if (tick_n_q == LAST_TICK) begin
                rate_o    <= run_q;
                rate_ok_o <= 1'b1;
                tick_n_q  <= '0;
                run_q     <= RATE_W'(1);
            end else begin
                tick_n_q <= tick_n_q + TICK_W'(1);
                run_q    <= run_inc;
            end
        end else if (started_q) begin
            run_q <= run_inc;
        end
    end

    AST_RATE_OK_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        rate_ok_o |=> rate_ok_o); // R4

    AST_RATE_ONLY_ON_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
        !ref_tick_i |=> $stable(rate_o)); // R4

endmodule

// File: rtl/ratio_classifier.sv
module ratio_classifier
    import clkdet_pkg::*;
#(
    parameter int unsigned PER_W    = 11,
    parameter int unsigned RATE_W   = 20,
    parameter int unsigned TOL      = 2,
    parameter int unsigned DBL_MIN  = 56,
    parameter int unsigned QUAD_MIN = 112
) (
    input  logic [PER_W-1:0]  period_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              match_o,
    output ratio_code_t       code_o,
    output speed_e            speed_o,
    output logic              legal_o,
    output logic [DIV_W-1:0]  div_half_o
);

    logic [NUM_RATIOS-1:0] hit;
    logic [31:0]           nominal;
    logic [31:0]           dbl_thr;
    logic [31:0]           quad_thr;

    for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_hit
        assign hit[i] = abs_diff(32'(period_i), ratio_of(ratio_code_t'(i))) <= TOL;
    end

    always_comb begin
        match_o = 1'b0;
        code_o  = '0;
        for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
            if (hit[i]) begin
                match_o = 1'b1;
                code_o  = ratio_code_t'(i);
            end
        end
    end

    always_comb begin
        nominal  = ratio_of(code_o);
        dbl_thr  = nominal * DBL_MIN;
        quad_thr = nominal * QUAD_MIN;
        if (32'(rate_i) >= quad_thr) begin
            speed_o = SPD_QUAD;
        end else if (32'(rate_i) >= dbl_thr) begin
            speed_o = SPD_DOUBLE;
        end else begin
            speed_o = SPD_SINGLE;
        end
    end

    assign legal_o    = legal_in(speed_o, code_o);
    assign div_half_o = half_div_of(code_o);

endmodule

// File: rtl/clk_ratio_detector.sv
module clk_ratio_detector
    import clkdet_pkg::*;
#(
    parameter int unsigned TOL       = 2,
    parameter int unsigned WIN_TICKS = 4,
    parameter int unsigned RATE_W    = 20,
    parameter int unsigned DBL_MIN   = 56,
    parameter int unsigned QUAD_MIN  = 112
) (
    input  logic       mclk_i,
    input  logic       rst_i,
    input  logic       frame_clk_i,
    input  logic       ref_tick_i,
    output logic       valid_o,
    output logic [3:0] ratio_code_o,
    output logic [1:0] speed_o,
    output logic [5:0] bclk_div_half_o
);

    localparam int unsigned PER_W = $clog2(2 * MAX_RATIO);

    logic              frame_rise;
    logic              period_evt;
    logic [PER_W-1:0]  period;
    logic [RATE_W-1:0] rate;
    logic              rate_ok;
    logic              match;
    ratio_code_t       code;
    speed_e            speed;
    logic              legal;
    logic [DIV_W-1:0]  div_half;

    logic [PER_W-1:0]  prev_per_q;
    logic              prev_ok_q;
    logic              stable;
    det_result_t       res_q;

    frame_period_meter #(.PER_W(PER_W)) u_period (
        .clk_i        (mclk_i),
        .rst_i        (rst_i),
        .frame_clk_i  (frame_clk_i),
        .rise_o       (frame_rise),
        .period_evt_o (period_evt),
        .period_o     (period)
    );

    mclk_rate_meter #(.WIN_TICKS(WIN_TICKS), .RATE_W(RATE_W)) u_rate (
        .clk_i      (mclk_i),
        .rst_i      (rst_i),
        .ref_tick_i (ref_tick_i),
        .rate_o     (rate),
        .rate_ok_o  (rate_ok)
    );

    ratio_classifier #(
        .PER_W    (PER_W),
        .RATE_W   (RATE_W),
        .TOL      (TOL),
        .DBL_MIN  (DBL_MIN),
        .QUAD_MIN (QUAD_MIN)
    ) u_class (
        .period_i   (period),
        .rate_i     (rate),
        .match_o    (match),
        .code_o     (code),
        .speed_o    (speed),
        .legal_o    (legal),
        .div_half_o (div_half)
    );

    assign stable = prev_ok_q && (abs_diff(32'(period), 32'(prev_per_q)) <= TOL);

    always_ff @(posedge mclk_i) begin
        if (rst_i) begin
            prev_per_q <= '0;
            prev_ok_q  <= 1'b0;
            res_q      <= '0;
        end else if (period_evt) begin
            prev_per_q <= period;
            prev_ok_q  <= 1'b1;
            if (stable && match && rate_ok && legal) begin
                res_q.valid    <= 1'b1;
                res_q.code     <= code;
                res_q.speed    <= speed;
                res_q.div_half <= div_half;
            end else begin
                res_q.valid <= 1'b0;
            end
        end
    end

    assign valid_o         = res_q.valid;
    assign ratio_code_o    = res_q.code;
    assign speed_o         = res_q.speed;
    assign bclk_div_half_o = res_q.div_half;

    AST_QUIET_BETWEEN_EDGES: assert property (@(posedge mclk_i) disable iff (rst_i)
        !frame_rise |=> $stable(res_q)); // R9

    AST_HOLD_ON_REJECT: assert property (@(posedge mclk_i) disable iff (rst_i)
        $fell(valid_o) |-> ($stable(ratio_code_o) && $stable(speed_o) && $stable(bclk_div_half_o))); // R7

    AST_DIV_TRACKS_RATIO: assert property (@(posedge mclk_i) disable iff (rst_i)
        valid_o |-> (32'(bclk_div_half_o) * 32 == ratio_of(ratio_code_o))); // R8

    AST_NO_VALID_WITHOUT_RATE: assert property (@(posedge mclk_i) disable iff (rst_i)
        !rate_ok |-> !valid_o); // R10

    AST_VALID_MODE_LEGAL: assert property (@(posedge mclk_i) disable iff (rst_i)
        valid_o |-> legal_in(speed_e'(speed_o), ratio_code_o)); // R6

endmodule

// File: tb/sim_clk_ratio_detector.sv
module sim_clk_ratio_detector;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lrck = 1'b0;
    logic       ref_tick = 1'b0;
    logic       valid;
    logic [3:0] code;
    logic [1:0] speed;
    logic [5:0] div_half;

    int per_a = 64;
    int per_b = 64;
    int tk    = 192;
    int checks = 0;
    int failures = 0;
    int r9_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    clk_ratio_detector #(
        .TOL(2), .WIN_TICKS(4), .RATE_W(20), .DBL_MIN(4), .QUAD_MIN(8)
    ) u0 (
        .mclk_i          (clk),
        .rst_i           (rst),
        .frame_clk_i     (lrck),
        .ref_tick_i      (ref_tick),
        .valid_o         (valid),
        .ratio_code_o    (code),
        .speed_o         (speed),
        .bclk_div_half_o (div_half)
    );

    // Frame clock: high for half the period, alternating per_a / per_b
    initial begin
        int p;
        bit alt;
        alt = 1'b0;
        @(negedge clk);
        forever begin
            p = alt ? per_b : per_a;
            alt = ~alt;
            lrck = 1'b1;
            repeat (p / 2) @(negedge clk);
            lrck = 1'b0;
            repeat (p - p / 2) @(negedge clk);
        end
    end

    // Reference tick: one cycle every tk cycles
    initial begin
        forever begin
            repeat (tk - 1) @(negedge clk);
            ref_tick = 1'b1;
            @(negedge clk);
            ref_tick = 1'b0;
        end
    end

    // R9 monitor: outputs may move only where the sampled frame clock rose
    initial begin
        logic [12:0] last_out;
        logic        last_lr;
        last_out = '0;
        last_lr  = 1'b1;
        forever begin
            @(posedge clk);
            #2;
            if (!rst && ({valid, code, speed, div_half} !== last_out) && !(lrck && !last_lr))
                r9_bad++;
            last_out = {valid, code, speed, div_half};
            last_lr  = rst ? 1'b1 : lrck;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic after_rise();
        @(posedge lrck);
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    // period, fs unit (x16 kHz), expected code, expected speed, expected div
    localparam int NVEC = 12;
    localparam int VEC [NVEC][5] = '{
        '{256,  3, 4, 0,  8},
        '{256,  6, 4, 1,  8},
        '{128,  6, 2, 1,  4},
        '{128, 12, 2, 2,  4},
        '{64,  12, 0, 2,  2},
        '{96,  12, 1, 2,  3},
        '{1152, 2, 9, 0, 36},
        '{512,  4, 6, 1, 16},
        '{384,  3, 5, 0, 12},
        '{192, 12, 3, 2,  6},
        '{768,  3, 7, 0, 24},
        '{1024, 2, 8, 0, 32}
    };

    initial begin
        int prev_win;
        prev_win = 64 * 12;

        // Reset state (R1)
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        chk("R1 valid", 32'(valid), 0);
        chk("R1 code", 32'(code), 0);
        chk("R1 speed", 32'(speed), 0);
        chk("R1 div", 32'(div_half), 0);

        // Before the first rate window closes (R10)
        settle(350);
        chk("R10 valid before window", 32'(valid), 0);
        settle(1000);
        chk("R10 valid after window", 32'(valid), 1);
        chk("R10 code after window", 32'(code), 0);

        // Table of ratio / rate combinations (R2 R4 R5 R8)
        for (int i = 0; i < NVEC; i++) begin
            int r;
            int f;
            r = VEC[i][0];
            f = VEC[i][1];
            per_a = r;
            per_b = r;
            tk = (r * f) / 4;
            settle(2 * prev_win + 2 * r * f + 6 * r + 100);
            prev_win = r * f;
            chk($sformatf("R2 vec%0d valid", i), 32'(valid), 1);
            chk($sformatf("R2 vec%0d code", i), 32'(code), 32'(VEC[i][2]));
            chk($sformatf("R5 vec%0d speed", i), 32'(speed), 32'(VEC[i][3]));
            chk($sformatf("R8 vec%0d div", i), 32'(div_half), 32'(VEC[i][4]));
        end

        // Tolerance edges at 256x single speed (R2 R7)
        per_a = 256; per_b = 256; tk = 192;
        settle(2 * prev_win + 2 * 768 + 6 * 256 + 100);
        chk("R2 base valid", 32'(valid), 1);
        per_a = 258; per_b = 258;
        settle(6 * 258);
        chk("R2 +2 accepted", 32'(valid), 1);
        chk("R2 +2 code", 32'(code), 4);
        per_a = 259; per_b = 259;
        settle(6 * 259);
        chk("R2 +3 rejected", 32'(valid), 0);
        chk("R7 code held", 32'(code), 4);
        chk("R7 div held", 32'(div_half), 8);
        per_a = 254; per_b = 254;
        settle(6 * 254);
        chk("R2 -2 accepted", 32'(valid), 1);

        // Periods that each match but disagree by 3 (R3)
        per_a = 255; per_b = 258;
        settle(8 * 258);
        chk("R3 unstable rejected", 32'(valid), 0);
        chk("R7 speed held", 32'(speed), 0);

        // Acceptance timing after a ratio change (R3)
        per_a = 256; per_b = 256;
        settle(8 * 258);
        chk("R3 restable", 32'(valid), 1);
        @(posedge lrck);
        per_a = 384; per_b = 384;
        @(posedge clk);
        #2;
        after_rise();
        chk("R3 old period still valid", 32'(valid), 1);
        after_rise();
        chk("R3 first new period rejected", 32'(valid), 0);
        chk("R3 first new period code held", 32'(code), 4);
        after_rise();
        chk("R3 second new period valid", 32'(valid), 1);
        chk("R3 second new period code", 32'(code), 5);
        chk("R8 384x div", 32'(div_half), 12);

        // Ratio illegal for detected mode (R6 R7)
        per_a = 64; per_b = 64; tk = 192;
        settle(2 * 768 + 2 * 768 + 600);
        chk("R6 quad 64x valid", 32'(valid), 1);
        tk = 48;
        settle(2 * 768 + 2 * 192 + 600);
        chk("R6 64x at single speed rejected", 32'(valid), 0);
        chk("R7 code held", 32'(code), 0);
        chk("R7 speed held", 32'(speed), 2);
        chk("R7 div held", 32'(div_half), 2);

        chk("R9 outputs move only at frame rise", 32'(r9_bad), 0);
        finish_run();
    end

endmodule